// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block sits on the memory side of a small multiprocessor and owns a word memory that several processor ports share. Every request names an operation, a word address and an operand. The unit serves one request at a time, reads the addressed word, optionally writes a new value, and returns the value that was there before. Because the read and the write of one request happen in the same execution cycle, no other port's access can land between them. That makes the unit usable for locks, counters and exchanges.

A port raises its valid line and holds its request until it sees its grant bit. A round-robin arbiter picks the winner each cycle. The request is latched on the edge that ends the grant cycle. It executes in the next cycle, where the read and the write happen together. The response, tagged with the port number, appears one cycle after that. Grants may follow one another in consecutive cycles, and each execution sees the write of the one before it.

A lock is taken by test-and-set. A returned 0 means the lock was acquired, and a returned 1 means another port already held it. The lock is released with a plain store of 0. A separate load followed by a store cannot give the same guarantee, because two ports can both read 0 before either one writes. The unit exists to close that gap.

Top module: `amo_unit`

## Requirements
- R1: After reset every memory word reads 0, no grant is asserted and `rsp_valid` is low.
- R2: Opcode 0 (load) returns the word and leaves it unchanged. Opcodes 5 to 7 behave exactly like a load.
- R3: Opcode 1 (store) writes the operand and returns the word's prior value.
- R4: Opcode 2 (test-and-set) returns the prior value and writes 1. A return of 0 means the lock was acquired, and a return of 1 means it was already held. A store of 0 releases the lock.
- R5: Opcode 3 (fetch-and-add) returns the prior value and writes prior plus operand modulo 2^W. No overflow indication exists.
- R6: Opcode 4 (swap) returns the prior value and writes the operand.
- R7: `req_gnt` is one-hot or zero, is set only for a port whose `req_valid` is high, and is set in every cycle in which at least one port requests.
- R8: Arbitration rotates. The search starts at the port after the last one granted, and port 0 is first after reset. A port that holds its request sees at most NPORT-1 other grants before its own.
- R9: A request granted in cycle t has its response visible in cycle t+2, which is one cycle after its write. The response carries the requesting port's index on `rsp_port`.
- R10: Requests that contend for one address are executed one after another in consecutive cycles, and each one sees the previous one's write. When several ports test-and-set a free lock at once, exactly one of them receives 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | NPORT | Per-port request valid, held until granted |
| req_op | input | 3*NPORT | Per-port opcode, port p in bits [3p+2:3p] |
| req_addr | input | AW*NPORT | Per-port word address |
| req_data | input | W*NPORT | Per-port operand |
| req_gnt | output | NPORT | One-hot grant, request accepted at the next edge |
| rsp_valid | output | 1 | Response valid |
| rsp_port | output | PW | Index of the port being answered |
| rsp_data | output | W | Value of the word before the operation |

## Verification
The bench builds the unit with four ports, 32-bit words and sixteen words of memory. Four ports are enough to show a complete rotation of the arbiter and a four-way test-and-set race on a single lock. A 32-bit word lets fetch-and-add be driven just below 2^32 so that the wrap can be seen. The sixteen-word depth puts the top address (15) within reach. Partial port masks, started from a known pointer position, show that the rotation skips idle ports.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_TAS   = 3'd2,
    OP_FADD  = 3'd3,
    OP_SWAP  = 3'd4
  } amo_op_e;
  localparam int OP_W = 3;
endpackage

// File: rtl/amo_rr_arb.sv
module amo_rr_arb #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  localparam int PW = (N > 1) ? $clog2(N) : 1;
  localparam int CW = $clog2(N + 1);

  logic [PW-1:0] last_q, last_d;
  logic [PW-1:0] idx;
  logic          found;

  // search starts just after the last winner
  always_comb begin
    gnt   = '0;
    found = 1'b0;
    idx   = '0;
    for (int off = 1; off <= N; off++) begin
      idx = PW'((int'(last_q) + off) % N);
      if (!found && req[idx]) begin
        gnt[idx] = 1'b1;
        found    = 1'b1;
      end
    end
  end

  always_comb begin
    last_d = last_q;
    for (int i = 0; i < N; i++) begin
      if (gnt[i]) last_d = PW'(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      last_q <= PW'(N - 1);
    else if (|gnt)   last_q <= last_d;
  end

  // R7: grant shape
  a_r7_gnt_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt));
  a_r7_gnt_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt & ~req) == '0);
  a_r7_no_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (|req) |-> (|gnt));

  // R8: a held request sees at most N-1 foreign grants
  generate
    for (genvar g = 0; g < N; g++) begin : g_wait
      logic [CW-1:0] wait_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     wait_q <= '0;
        else if (!req[g] || gnt[g])     wait_q <= '0;
        else if (|gnt)                  wait_q <= wait_q + 1'b1;
      end
      a_r8_fair: assert property (@(posedge clk) disable iff (!rst_n)
        wait_q <= CW'(N - 1));
    end
  endgenerate
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    old_val,
  input  logic [W-1:0]    operand,
  output logic [W-1:0]    new_val,
  output logic            wr_en
);
  always_comb begin
    new_val = old_val;
    wr_en   = 1'b0;
    case (op)
      OP_STORE: begin new_val = operand;           wr_en = 1'b1; end
      OP_TAS:   begin new_val = W'(1);             wr_en = 1'b1; end
      OP_FADD:  begin new_val = old_val + operand; wr_en = 1'b1; end
      OP_SWAP:  begin new_val = operand;           wr_en = 1'b1; end
      default:  begin new_val = old_val;           wr_en = 1'b0; end
    endcase
  end
endmodule

// File: rtl/amo_mem.sv
module amo_mem #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(DEPTH)-1:0] addr,
  output logic [W-1:0]             rdata,
  input  logic                     we,
  input  logic [W-1:0]             wdata
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0] mem_q [DEPTH];

  generate
    for (genvar k = 0; k < DEPTH; k++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        mem_q[k] <= '0;
        else if (we && addr == AW'(k))     mem_q[k] <= wdata;
      end
    end
  endgenerate

  assign rdata = mem_q[addr];

  // R3: a write is visible in the following cycle
  a_r3_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> mem_q[$past(addr)] == $past(wdata));
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int W     = 32,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      req_valid,
  input  logic [NPORT*OP_W-1:0] req_op,
  input  logic [NPORT*AW-1:0]   req_addr,
  input  logic [NPORT*W-1:0]    req_data,
  output logic [NPORT-1:0]      req_gnt,
  output logic                  rsp_valid,
  output logic [PW-1:0]         rsp_port,
  output logic [W-1:0]          rsp_data
);
  // grant stage
  logic [OP_W-1:0] sel_op;
  logic [AW-1:0]   sel_addr;
  logic [W-1:0]    sel_data;
  logic [PW-1:0]   sel_port;

  // execute stage
  logic            ex_vld_q, ex_vld_d;
  logic [OP_W-1:0] ex_op_q, ex_op_d;
  logic [AW-1:0]   ex_addr_q, ex_addr_d;
  logic [W-1:0]    ex_opnd_q, ex_opnd_d;
  logic [PW-1:0]   ex_port_q, ex_port_d;

  logic [W-1:0]    mem_rdata, alu_new;
  logic            alu_we, mem_we;

  logic            rsp_vld_d;
  logic [PW-1:0]   rsp_port_d;
  logic [W-1:0]    rsp_data_d;

  amo_rr_arb #(.N(NPORT)) u_arb (
    .clk (clk),
    .rst_n (rst_n),
    .req (req_valid),
    .gnt (req_gnt)
  );

  always_comb begin
    sel_op   = '0;
    sel_addr = '0;
    sel_data = '0;
    sel_port = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (req_gnt[i]) begin
        sel_op   = sel_op   | req_op[i*OP_W +: OP_W];
        sel_addr = sel_addr | req_addr[i*AW +: AW];
        sel_data = sel_data | req_data[i*W +: W];
        sel_port = sel_port | PW'(i);
      end
    end
  end

  always_comb begin
    ex_vld_d  = |req_gnt;
    ex_op_d   = sel_op;
    ex_addr_d = sel_addr;
    ex_opnd_d = sel_data;
    ex_port_d = sel_port;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_vld_q  <= 1'b0;
      ex_op_q   <= '0;
      ex_addr_q <= '0;
      ex_opnd_q <= '0;
      ex_port_q <= '0;
    end else begin
      ex_vld_q <= ex_vld_d;
      if (ex_vld_d) begin
        ex_op_q   <= ex_op_d;
        ex_addr_q <= ex_addr_d;
        ex_opnd_q <= ex_opnd_d;
        ex_port_q <= ex_port_d;
      end
    end
  end

  amo_alu #(.W(W)) u_alu (
    .op      (ex_op_q),
    .old_val (mem_rdata),
    .operand (ex_opnd_q),
    .new_val (alu_new),
    .wr_en   (alu_we)
  );

  assign mem_we = ex_vld_q && alu_we;

  amo_mem #(.W(W), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .rst_n (rst_n),
    .addr  (ex_addr_q),
    .rdata (mem_rdata),
    .we    (mem_we),
    .wdata (alu_new)
  );

  always_comb begin
    rsp_vld_d  = ex_vld_q;
    rsp_port_d = ex_port_q;
    rsp_data_d = mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_port  <= '0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= rsp_vld_d;
      if (rsp_vld_d) begin
        rsp_port <= rsp_port_d;
        rsp_data <= rsp_data_d;
      end
    end
  end

  // R9: grant -> execute -> response, port id carried through
  a_r9_gnt_to_exec: assert property (@(posedge clk) disable iff (!rst_n)
    (|req_gnt) |=> ex_vld_q);
  a_r9_exec_to_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    ex_vld_q |=> (rsp_valid && rsp_port == $past(ex_port_q)));
  a_r9_rsp_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(ex_vld_q));
  // R4: test-and-set leaves the location holding 1
  a_r4_tas_sets_one: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld_q && ex_op_q == OP_TAS && ex_vld_d && sel_addr == ex_addr_q)
      |=> (mem_rdata == W'(1)));
endmodule

// File: tb/amo_unit_bench.sv
`timescale 1ns/1ps
module amo_unit_bench;
  localparam int NPORT = 4;
  localparam int W     = 32;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int PW    = 2;

  logic                 clk = 1'b0;
  logic                 rst_n;
  logic [NPORT-1:0]     req_valid;
  logic [NPORT*3-1:0]   req_op;
  logic [NPORT*AW-1:0]  req_addr;
  logic [NPORT*W-1:0]   req_data;
  logic [NPORT-1:0]     req_gnt;
  logic                 rsp_valid;
  logic [PW-1:0]        rsp_port;
  logic [W-1:0]         rsp_data;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  amo_unit #(.NPORT(NPORT), .W(W), .DEPTH(DEPTH)) u_amo_unit (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_op (req_op), .req_addr (req_addr),
    .req_data (req_data), .req_gnt (req_gnt),
    .rsp_valid (rsp_valid), .rsp_port (rsp_port), .rsp_data (rsp_data)
  );

  typedef struct packed {
    logic [1:0]  port;
    logic [2:0]  op;
    logic [3:0]  addr;
    logic [31:0] opnd;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd0, 4'd3,  32'h0,        32'h0,        4'd1},  // R1 fresh word
    '{2'd1, 3'd1, 4'd3,  32'h12345678, 32'h0,        4'd3},  // R3
    '{2'd2, 3'd0, 4'd3,  32'h0,        32'h12345678, 4'd2},  // R2
    '{2'd3, 3'd2, 4'd7,  32'h0,        32'h0,        4'd4},  // R4 acquire
    '{2'd0, 3'd2, 4'd7,  32'h0,        32'h1,        4'd4},  // R4 held
    '{2'd3, 3'd1, 4'd7,  32'h0,        32'h1,        4'd4},  // R4 release
    '{2'd1, 3'd2, 4'd7,  32'h0,        32'h0,        4'd4},  // R4 reacquire
    '{2'd2, 3'd3, 4'd3,  32'h5,        32'h12345678, 4'd5},  // R5
    '{2'd0, 3'd0, 4'd3,  32'h0,        32'h1234567D, 4'd5},  // R5 sum
    '{2'd1, 3'd1, 4'd9,  32'hFFFFFFFE, 32'h0,        4'd3},  // R3
    '{2'd3, 3'd3, 4'd9,  32'h3,        32'hFFFFFFFE, 4'd5},  // R5 wrap
    '{2'd0, 3'd0, 4'd9,  32'h0,        32'h00000001, 4'd5},  // R5 wrapped
    '{2'd2, 3'd4, 4'd3,  32'hA5A5A5A5, 32'h1234567D, 4'd6},  // R6
    '{2'd1, 3'd0, 4'd3,  32'h0,        32'hA5A5A5A5, 4'd6},  // R6 landed
    '{2'd0, 3'd7, 4'd3,  32'h0,        32'hA5A5A5A5, 4'd2},  // R2 code 7
    '{2'd3, 3'd0, 4'd3,  32'h0,        32'hA5A5A5A5, 4'd2},  // R2 unchanged
    '{2'd1, 3'd4, 4'd15, 32'hDEAD0001, 32'h0,        4'd6},  // R6 top word
    '{2'd2, 3'd0, 4'd15, 32'h0,        32'hDEAD0001, 4'd6}   // R6 top word
  };

  function automatic string rname(input int n);
    case (n)
      1: return "R1";  2: return "R2";  3: return "R3";  4: return "R4";
      5: return "R5";  6: return "R6";  7: return "R7";  8: return "R8";
      9: return "R9";  default: return "R10";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic drive(input int p, input logic [2:0] op, input logic [3:0] a,
                       input logic [31:0] d);
    req_op[p*3 +: 3]    = op;
    req_addr[p*AW +: AW] = a;
    req_data[p*W +: W]  = d;
    req_valid[p]        = 1'b1;
  endtask

  task automatic do_reset();
    rst_n     = 1'b0;
    req_valid = '0;
    req_op    = '0;
    req_addr  = '0;
    req_data  = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // single request, checks grant, latency and response
  task automatic single(input int p, input logic [2:0] op, input logic [3:0] a,
                        input logic [31:0] d, input logic [31:0] exp,
                        input string tag);
    @(negedge clk);
    drive(p, op, a, d);
    #1;
    check(req_gnt == 4'(1 << p), "R7 grant", 32'(req_gnt), 32'(1 << p));
    @(negedge clk);
    req_valid[p] = 1'b0;
    #1;
    check(!rsp_valid, "R9 not early", 32'(rsp_valid), 32'h0);
    @(negedge clk);
    #1;
    check(rsp_valid, "R9 valid at t+2", 32'(rsp_valid), 32'h1);
    check(rsp_port == PW'(p), "R9 port", 32'(rsp_port), 32'(p));
    check(rsp_data == exp, tag, rsp_data, exp);
  endtask

  int            g_order [4];
  int            g_cyc   [4];
  logic [PW-1:0] r_port  [4];
  logic [W-1:0]  r_data  [4];

  task automatic contend(input logic [3:0] mask, input logic [2:0] op,
                         input logic [3:0] a, input logic [31:0] d);
    int n;
    int ng;
    int nr;
    int cyc;
    logic [3:0] pending;
    n = $countones(mask);
    ng = 0; nr = 0; cyc = 0;
    pending = mask;
    @(negedge clk);
    for (int p = 0; p < NPORT; p++) if (mask[p]) drive(p, op, a, d);
    while (nr < n && cyc < 40) begin
      #1;
      if (rsp_valid && nr < 4) begin
        r_port[nr] = rsp_port;
        r_data[nr] = rsp_data;
        nr++;
      end
      for (int p = 0; p < NPORT; p++) begin
        if (req_gnt[p] && ng < 4) begin
          g_order[ng] = p;
          g_cyc[ng]   = cyc;
          ng++;
        end
      end
      pending = pending & ~req_gnt;
      @(negedge clk);
      req_valid = req_valid & pending;
      cyc++;
    end
    check(nr == n, "R10 all answered", 32'(nr), 32'(n));
  endtask

  initial begin
    #500000;
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1: quiescent after reset
    #1;
    check(!rsp_valid, "R1 rsp_valid", 32'(rsp_valid), 32'h0);
    check(req_gnt == '0, "R1 grant", 32'(req_gnt), 32'h0);

    for (int i = 0; i < NV; i++) begin
      single(int'(VEC[i].port), VEC[i].op, VEC[i].addr, VEC[i].opnd,
             VEC[i].exp, rname(int'(VEC[i].req)));
    end

    // R10/R8: four-way test-and-set race on a free lock, after reset
    do_reset();
    contend(4'b1111, 3'd2, 4'd5, 32'h0);
    for (int k = 0; k < 4; k++) begin
      check(g_order[k] == k, "R8 rotation order", 32'(g_order[k]), 32'(k));
      check(r_port[k] == PW'(k), "R9 port in race", 32'(r_port[k]), 32'(k));
      check(r_data[k] == (k == 0 ? 32'h0 : 32'h1), "R10 single winner",
            r_data[k], (k == 0 ? 32'h0 : 32'h1));
      if (k > 0)
        check(g_cyc[k] == g_cyc[k-1] + 1, "R10 back-to-back",
              32'(g_cyc[k]), 32'(g_cyc[k-1] + 1));
    end

    // R8: skip idle ports, pointer sits at 3 so port 1 goes first
    contend(4'b1010, 3'd3, 4'd2, 32'h7);
    check(g_order[0] == 1 && g_order[1] == 3, "R8 skip idle",
          32'(g_order[0] * 16 + g_order[1]), 32'h13);
    check(r_data[0] == 32'h0 && r_data[1] == 32'h7, "R10 add sees add",
          r_data[1], 32'h7);
    single(0, 3'd0, 4'd2, 32'h0, 32'd14, "R5 two adds");

    // pointer now at 0: port 2 then port 3 in a store race on the lock
    contend(4'b1100, 3'd1, 4'd5, 32'h0);
    check(g_order[0] == 2 && g_order[1] == 3, "R8 wrap order",
          32'(g_order[0] * 16 + g_order[1]), 32'h23);
    check(r_data[0] == 32'h1 && r_data[1] == 32'h0, "R4 release by store",
          r_data[0], 32'h1);
    single(1, 3'd2, 4'd5, 32'h0, 32'h0, "R4 acquire after release");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule